// File: doc/BRIEF.md
# Programmable Frequency Clock Synthesizer

This block derives a slower event train from one fixed system clock at a frequency chosen at run time. A tuning word, loaded through a single-cycle write port, is added on every system clock to a recirculating phase accumulator. Each time the accumulator passes its modulus, the block raises a one-cycle `tick`. A square wave that flips on every tick is also provided, at half the tick rate.

The accumulator modulus is a parameter. When it is set equal to the system clock frequency in hertz, the tuning word is the output tick rate in hertz. This holds whether or not that frequency is a power of two. With a power-of-two modulus, the wrap reduces to the natural binary carry of the adder. For any other modulus, a compare-and-subtract stage is built instead.

When the tuning word does not divide the modulus evenly, the spacing between ticks varies by one system cycle. The long-term rate is still exact. Words at or above half the modulus would alias, so they are clamped when written, and a status output reports that the clamp was applied.

Top module: `fs_clock_synth`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tick`, `sq_out` and `word_capped` are 0. Reset also clears the accumulator and the stored tuning word to 0.
- R2: On each clock edge the accumulator becomes (acc + word) when that sum is below the modulus M. Otherwise it becomes (acc + word - M) and a carry occurs. The accumulator always stays within 0..M-1.
- R3: `tick` is high for exactly the one cycle after each edge that produces a carry. With a constant word W, exactly W ticks appear in any window of M consecutive cycles.
- R4: A stored tuning word of 0 produces no tick at all.
- R5: When W does not divide M, consecutive ticks are spaced either floor(M/W) or ceil(M/W) cycles apart.
- R6: A word written with `wr_en` is stored at that edge and is first added at the following edge. A write never disturbs the accumulator phase.
- R7: A written word greater than M/2-1 is stored as M/2-1 and sets `word_capped` to 1. A word within range is stored unchanged and sets `word_capped` to 0. Both outputs are visible one cycle after the write edge.
- R8: `sq_out` inverts on every edge that raises `tick` and holds otherwise, so it equals the parity of the ticks seen since reset.
- R9: With a power-of-two modulus M = 2^ACC_W, the block produces the same counts (R3) and clamp (R7) using the plain adder carry.
- R10: `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load `wr_word` into the tuning register this edge |
| wr_word | input | ACC_W | Requested tuning word (events per M cycles) |
| tick | output | 1 | One-cycle pulse per accumulator wrap |
| sq_out | output | 1 | Square wave toggled by each tick |
| word_capped | output | 1 | Last written word exceeded M/2-1 and was clamped |

## Verification
The assertions assume that `rst_n` is driven low from time zero, so the reset-state property has defined values at its first edge. They also assume the stored word is clamped, which is why the no-back-to-back-tick rule can hold for any write sequence. The bench drives the reset from its first instant and changes inputs only at falling edges. It deliberately writes words above the clamp limit, so the bound on the stored word is exercised rather than assumed. Two instances are run side by side: a non-power-of-two modulus of 200 and a power-of-two modulus of 64. This keeps every full-modulus counting window short.

// File: rtl/fs_pkg.sv
// Package: shared helpers for the frequency synthesizer.
// Assumes modulus values fit in a 32-bit int and are at least 4.
package fs_pkg;

    // Largest tuning word that stays below half the modulus.
    function automatic int fs_word_limit(input int modulus);
        return (modulus / 2) - 1;
    endfunction

    // True when the modulus equals the natural range of the adder.
    function automatic bit fs_is_pow2(input int modulus, input int width);
        return modulus == (1 << width);
    endfunction

endpackage

// File: rtl/fs_tune_reg.sv
// Module: tuning-word register with aliasing clamp.
// Stores the requested word on wr_en, limited to MODULUS/2-1, and reports
// whether the limit was applied. Assumes MODULUS <= 2**ACC_W.
module fs_tune_reg #(
    parameter int ACC_W   = 20,
    parameter int MODULUS = 1048576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_word,
    output logic [ACC_W-1:0] word_q,
    output logic             capped_q
);
    import fs_pkg::*;

    localparam logic [ACC_W-1:0] LIMIT_W = ACC_W'(fs_word_limit(MODULUS));

    logic             over_limit;
    logic [ACC_W-1:0] word_next;

    // Decide whether the requested word must be clamped.
    always_comb begin
        over_limit = (wr_word > LIMIT_W);
        word_next  = over_limit ? LIMIT_W : wr_word;
    end

    // Hold the tuning word and the clamp status until the next write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            capped_q <= 1'b0;
        end else if (wr_en) begin
            word_q   <= word_next;
            capped_q <= over_limit;
        end
    end

endmodule

// File: rtl/fs_phase_acc.sv
// Module: modulo-M phase accumulator.
// Adds inc to the phase every cycle and wraps at MODULUS, flagging the wrap
// on carry (combinational, same cycle as the sum). Assumes inc < MODULUS.
module fs_phase_acc #(
    parameter int ACC_W   = 20,
    parameter int MODULUS = 1048576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry
);
    import fs_pkg::*;

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_next;

    // Widen both operands so the adder carry is never lost.
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, inc};
    end

    generate
        if (fs_is_pow2(MODULUS, ACC_W)) begin : g_bin_wrap
            // Power-of-two modulus: the adder's top bit is the wrap.
            always_comb begin
                carry    = sum[ACC_W];
                acc_next = sum[ACC_W-1:0];
            end
        end else begin : g_mod_wrap
            localparam logic [ACC_W:0] MOD_EXT = (ACC_W+1)'(MODULUS);
            logic [ACC_W:0] reduced;
            // General modulus: subtract M whenever the sum reaches it.
            always_comb begin
                reduced  = sum - MOD_EXT;
                carry    = (sum >= MOD_EXT);
                acc_next = carry ? reduced[ACC_W-1:0] : sum[ACC_W-1:0];
            end
        end
    endgenerate

    // Advance the phase once per system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/fs_wave_out.sv
// Module: output stage turning the wrap flag into a pulse and a square wave.
// Registers the carry as a one-cycle tick and toggles a square-wave flop on
// each carry. Assumes carry is never high on consecutive cycles.
module fs_wave_out (
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    output logic tick_q,
    output logic sq_q
);

    // Register the pulse and flip the square wave on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            sq_q   <= 1'b0;
        end else begin
            tick_q <= carry;
            sq_q   <= sq_q ^ carry;
        end
    end

endmodule

// File: rtl/fs_clock_synth.sv
// Module: programmable frequency clock synthesizer (top).
// Tuning word in, tick pulse and square wave out; MODULUS should equal the
// system clock rate in hertz for hertz-valued tuning words.
// Assumes 4 <= MODULUS <= 2**ACC_W.
module fs_clock_synth #(
    parameter int ACC_W   = 20,
    parameter int MODULUS = 1048576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_word,
    output logic             tick,
    output logic             sq_out,
    output logic             word_capped
);

    logic [ACC_W-1:0] word_q;
    logic [ACC_W-1:0] acc_q;
    logic             carry;

    fs_tune_reg #(.ACC_W(ACC_W), .MODULUS(MODULUS)) u_tune (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .word_q   (word_q),
        .capped_q (word_capped)
    );

    fs_phase_acc #(.ACC_W(ACC_W), .MODULUS(MODULUS)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (word_q),
        .acc_q (acc_q),
        .carry (carry)
    );

    fs_wave_out u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .carry  (carry),
        .tick_q (tick),
        .sq_q   (sq_out)
    );

endmodule

// File: rtl/fs_clock_synth_chk.sv
// Module: assertion checker bound to fs_clock_synth.
// Observes ports plus the stored word and phase; drives nothing.
module fs_clock_synth_chk #(
    parameter int ACC_W   = 20,
    parameter int MODULUS = 1048576
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             sq_out,
    input logic             word_capped,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] word
);
    localparam logic [ACC_W:0] MOD_EXT   = (ACC_W+1)'(MODULUS);
    localparam logic [ACC_W-1:0] LIMIT_W = ACC_W'(MODULUS/2 - 1);

    // R1: reset leaves every output low on the next cycle.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tick && !sq_out && !word_capped));

    // R2: the phase never leaves 0..M-1.
    p_acc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, acc} < MOD_EXT));

    // R4: a zero word in force at the edge gives no tick after it.
    p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(word) == '0) |-> !tick);

    // R7: the stored word never exceeds the clamp limit.
    p_word_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word <= LIMIT_W));

    // R8: the square wave flips exactly when a tick appears.
    p_sq_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !$stable(sq_out));
    p_sq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(sq_out));

    // R10: ticks are isolated single-cycle pulses.
    p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

bind fs_clock_synth fs_clock_synth_chk #(.ACC_W(ACC_W), .MODULUS(MODULUS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sq_out      (sq_out),
    .word_capped (word_capped),
    .acc         (acc_q),
    .word        (word_q)
);

// File: tb/fs_clock_synth_test.sv
// Bench: directed scenarios on a modulus-200 instance and a modulus-64 one.
module fs_clock_synth_test;
    localparam int CLK_PERIOD = 10;
    localparam int W_A = 8;
    localparam int M_A = 200;
    localparam int W_B = 6;
    localparam int M_B = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en_a = 1'b0;
    logic [W_A-1:0] wr_word_a = '0;
    logic           tick_a, sq_a, cap_a;
    logic           wr_en_b = 1'b0;
    logic [W_B-1:0] wr_word_b = '0;
    logic           tick_b, sq_b, cap_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fs_clock_synth #(.ACC_W(W_A), .MODULUS(M_A)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_word(wr_word_a),
        .tick(tick_a), .sq_out(sq_a), .word_capped(cap_a));

    fs_clock_synth #(.ACC_W(W_B), .MODULUS(M_B)) uut_p2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_word(wr_word_b),
        .tick(tick_b), .sq_out(sq_b), .word_capped(cap_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Writes a word at a falling edge; returns at the falling edge after the store.
    task automatic write_word(input bit sel_b, input int w);
        @(negedge clk);
        if (sel_b) begin wr_en_b = 1'b1; wr_word_b = W_B'(w); end
        else       begin wr_en_a = 1'b1; wr_word_a = W_A'(w); end
        @(negedge clk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
    endtask

    // Samples the next `cycles` falling edges; counts ticks, gaps, sq parity errors.
    task automatic count_ticks(input bit sel_b, input int cycles, output int n,
                               output int gmin, output int gmax, output int sq_bad);
        int  last = -1;
        bit  par  = sel_b ? sq_b : sq_a;
        n = 0; gmin = 1 << 30; gmax = 0; sq_bad = 0;
        for (int i = 0; i < cycles; i++) begin
            bit t, s;
            @(negedge clk);
            t = sel_b ? tick_b : tick_a;
            s = sel_b ? sq_b : sq_a;
            if (t) begin
                n++;
                par = ~par;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
            if (s != par) sq_bad++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(tick_a == 1'b0, "R1 tick", int'(tick_a), 0);
        check(sq_a == 1'b0, "R1 sq_out", int'(sq_a), 0);
        check(cap_a == 1'b0, "R1 word_capped", int'(cap_a), 0);
    endtask

    task automatic t_exact_count();
        int n, g0, g1, sb;
        write_word(1'b0, 50);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 50, "R3 count W=50", n, 50);
        check(g0 == 4 && g1 == 4, "R2 spacing W=50", g1, 4);
        check(sb == 0, "R8 sq parity W=50", sb, 0);
        write_word(1'b0, 1);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 1, "R3 count W=1", n, 1);
    endtask

    task automatic t_zero_word();
        int n, g0, g1, sb;
        write_word(1'b0, 0);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 0, "R4 no ticks at W=0", n, 0);
    endtask

    task automatic t_jitter();
        int n, g0, g1, sb;
        write_word(1'b0, 7);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 7, "R5 count W=7", n, 7);
        check(g0 >= 28 && g1 <= 29, "R5 gap range", g0 * 100 + g1, 2829);
        check(sb == 0, "R8 sq parity W=7", sb, 0);
    endtask

    // From a cleared phase: 50 at E0 -> phase 50 (E1), 100 (E2); 100 written
    // for E3 where 50 is still added -> 150; E4 adds 100 -> wrap.
    task automatic t_phase_kept();
        do_reset();
        write_word(1'b0, 50);
        @(negedge clk);
        check(tick_a == 1'b0, "R6 no tick after E1", int'(tick_a), 0);
        @(negedge clk);
        wr_en_a = 1'b1; wr_word_a = 8'd100;
        @(negedge clk);
        wr_en_a = 1'b0;
        check(tick_a == 1'b0, "R6 old word used at store edge", int'(tick_a), 0);
        @(negedge clk);
        check(tick_a == 1'b1, "R6 phase kept through write", int'(tick_a), 1);
        @(negedge clk);
        check(tick_a == 1'b0, "R10 single-cycle tick", int'(tick_a), 0);
    endtask

    task automatic t_clamp();
        int n, g0, g1, sb;
        write_word(1'b0, 150);
        check(cap_a == 1'b1, "R7 capped flag set", int'(cap_a), 1);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 99, "R7 clamped count", n, 99);
        check(g1 <= 3 && g0 >= 2, "R10 clamped spacing", g0, 2);
        write_word(1'b0, 60);
        check(cap_a == 1'b0, "R7 capped flag cleared", int'(cap_a), 0);
        count_ticks(1'b0, M_A, n, g0, g1, sb);
        check(n == 60, "R7 in-range word unchanged", n, 60);
    endtask

    task automatic t_reset_midrun();
        write_word(1'b0, 3);
        repeat (100) @(negedge clk);
        do_reset();
        check(sq_a == 1'b0 && tick_a == 1'b0, "R1 mid-run reset", int'(sq_a), 0);
        write_word(1'b0, 50);
        repeat (3) @(negedge clk);
        check(tick_a == 1'b0, "R1 phase cleared (no early tick)", int'(tick_a), 0);
        @(negedge clk);
        check(tick_a == 1'b1, "R1 phase cleared (tick at 4th edge)", int'(tick_a), 1);
    endtask

    task automatic t_pow2();
        int n, g0, g1, sb;
        write_word(1'b1, 5);
        count_ticks(1'b1, M_B, n, g0, g1, sb);
        check(n == 5, "R9 pow2 count W=5", n, 5);
        check(sb == 0, "R9 pow2 sq parity", sb, 0);
        write_word(1'b1, 40);
        check(cap_b == 1'b1, "R9 pow2 capped flag", int'(cap_b), 1);
        count_ticks(1'b1, M_B, n, g0, g1, sb);
        check(n == 31, "R9 pow2 clamped count", n, 31);
    endtask

    initial begin
        t_reset_state();
        t_exact_count();
        t_zero_word();
        t_jitter();
        t_phase_kept();
        t_clamp();
        t_reset_midrun();
        t_pow2();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule